// File: doc/BRIEF.md
# Sequenced-Control Watchdog Timer

This block is a watchdog down-counter for a small microcontroller. Software reaches it through a single-cycle register write port and a combinational read port. Each of three control actions takes two writes to one control bit: first a 1, then a 0. These actions are arming the counter, servicing it, and switching it off. A single write of either value does nothing on its own. The idea is that one stray store from software that has lost control cannot start, feed or stop the watchdog.

Once armed, the counter counts down from a programmable period. If it reaches zero before a service sequence reloads it, the watchdog fires. A static configuration input selects what firing does:
- In reset mode it drives a system reset pulse 4 clocks long. The pulse returns the watchdog's own control state to disabled.
- In interrupt mode it sets a sticky flag and the counter keeps running. The flag raises an interrupt request when the local enable and the global enable are both on. It can also drive a wake output while the system is idle, gated by its own wake enable.

The block has no data stream, so it has no valid/ready handshake. Every write is accepted in the cycle it is presented, and the port applies no back-pressure.

Top module: `wdog_seq_top`

## Requirements
- R1: While armed, the count falls by exactly one per clock. Completing the arm sequence loads the count with the period register. The arm sequence is a CTRL write (address 0) with bit 0 = 1, then the next CTRL write with bit 0 = 0.
- R2: Disabling takes a CTRL write with bit 2 = 1, then the next CTRL write with bit 2 = 0. A write of bit 2 = 1 alone, or of bit 2 = 0 not preceded by a 1, leaves the watchdog armed.
- R3: While disabled, the count holds and nothing fires. A completed service sequence does not re-arm the counter; only the arm sequence does.
- R4: Suppose the period P is loaded at clock edge E. If no service sequence follows, the watchdog fires at edge E+P+1 and not before.
- R5: The input cfg_rst_mode selects the expiry action: 1 gives a system reset pulse, 0 sets the interrupt flag. No flag is set in reset mode.
- R6: irq_o is high exactly when the flag is set, the local enable (CTRL bit 3) is 1 and glb_irq_en is 1.
- R7: The flag is sticky. A write to STATUS (address 2) with bit 0 = 0 clears it. A write with bit 0 = 1 leaves it unchanged.
- R8: The service sequence reloads the count with the period while the counter is armed. It is a CTRL write with bit 1 = 1, then the next CTRL write with bit 1 = 0.
- R9: wake_o is high only while idle_i is 1, the wake enable (CTRL bit 4) is 1 and the interrupt request is high.
- R10: sys_rst_o stays high for exactly 4 clocks. Afterwards the watchdog is disarmed, with the local enable and the wake enable at 0. The period register keeps its value.
- R11: In interrupt mode, firing reloads the count with the period, and the counter keeps running.
- R12: Reads are combinational:
  - address 0 returns armed (bit 0), local enable (bit 3) and wake enable (bit 4);
  - address 1 returns the period;
  - address 2 returns the flag in bit 0;
  - address 3 returns the count.
  - After reset, the count reads 0, CTRL reads 0 and the period reads 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Read data, combinational |
| cfg_rst_mode | input | 1 | Static expiry action: 1 reset, 0 interrupt |
| glb_irq_en | input | 1 | Global interrupt enable |
| idle_i | input | 1 | System is in idle mode |
| sys_rst_o | output | 1 | System reset pulse |
| irq_o | output | 1 | Watchdog interrupt request |
| wake_o | output | 1 | Idle wake-up request |

## Verification
The assertions take cfg_rst_mode to be static while the watchdog can fire. A change of mode while a pulse or flag is pending would make the check on the pulse's origin meaningless. They also take each write to be one clean cycle with a defined address. The stimulus changes the mode only after a disable sequence has completed and the flag has been cleared. It drives every write for exactly one clock, away from the active edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_PERIOD = 2'd1;
  localparam logic [1:0] A_STAT   = 2'd2;
  localparam logic [1:0] A_COUNT  = 2'd3;

  // sequenced control bits; index equals CTRL bit position
  localparam int B_ARM  = 0;
  localparam int B_KICK = 1;
  localparam int B_STOP = 2;
  localparam int N_SEQ  = 3;
  // level control bits
  localparam int B_IE   = 3;
  localparam int B_WAKE = 4;
endpackage

// File: rtl/wdog_seq_bit.sv
// Detects a write of 1 followed by a write of 0 to one control bit.
module wdog_seq_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr,
  input  logic bit_val,
  output logic done
);
  logic pend;

  assign done = wr && !bit_val && pend && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (clr) pend <= 1'b0;
    else if (wr)  pend <= bit_val;
  end

  // R2: a completed sequence consumes the pending 1
  a_r2_seq_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !pend);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rst_mode,
  input  logic             arm_go,
  input  logic             kick_go,
  input  logic             stop_go,
  input  logic [CNT_W-1:0] period,
  output logic             armed,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic reload;

  assign reload = !clr && !stop_go && (arm_go || (kick_go && armed));
  assign expire = armed && !clr && !reload && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   armed <= 1'b0;
    else if (clr || stop_go)      armed <= 1'b0;
    else if (arm_go)              armed <= 1'b1;
    else if (expire && rst_mode)  armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count <= '0;
    else if (reload || expire)         count <= period;
    else if (armed && !clr && !stop_go) count <= count - CNT_W'(1);
  end

  // R1: steady down-count while armed
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !reload && !expire && !clr && !stop_go) |=> (count == $past(count) - CNT_W'(1)));
  // R3: only the arm sequence leaves the disabled state
  a_r3_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm_go) |=> !armed);
  // R3: disabled count holds
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm_go) |=> $stable(count));
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int PW = $clog2(LEN + 1);
  logic [PW-1:0] cnt;

  assign active = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (start)  cnt <= PW'(LEN);
    else if (active) cnt <= cnt - PW'(1);
  end

  // R10: pulse begins at full length and ends after its last count
  a_r10_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (cnt == PW'(LEN)));
  a_r10_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == PW'(1) && !start) |=> !active);
endmodule

// File: rtl/wdog_irq_ctrl.sv
module wdog_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set_flag,
  input  logic ctrl_wr,
  input  logic ie_val,
  input  logic wake_val,
  input  logic stat_wr,
  input  logic stat_bit,
  input  logic glb_en,
  input  logic idle,
  output logic flag,
  output logic ie,
  output logic wake_en,
  output logic irq,
  output logic wake
);
  logic flag_clr;
  assign flag_clr = stat_wr && !stat_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (set_flag) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie      <= 1'b0;
      wake_en <= 1'b0;
    end else if (clr) begin
      ie      <= 1'b0;
      wake_en <= 1'b0;
    end else if (ctrl_wr) begin
      ie      <= ie_val;
      wake_en <= wake_val;
    end
  end

  assign irq  = flag && ie && glb_en;
  assign wake = irq && wake_en && idle;

  // R7: flag holds until a clearing write
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
  // R7: flag only rises on an expiry
  a_r7_flag_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_flag));
endmodule

// File: rtl/wdog_seq_top.sv
module wdog_seq_top #(
  parameter int          DATA_W     = 16,
  parameter int          CNT_W      = 16,
  parameter int          PULSE_LEN  = 4,
  parameter logic [15:0] DEF_PERIOD = 16'd1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cfg_rst_mode,
  input  logic              glb_irq_en,
  input  logic              idle_i,
  output logic              sys_rst_o,
  output logic              irq_o,
  output logic              wake_o
);
  import wdog_pkg::*;

  logic             ctrl_wr, per_wr, stat_wr;
  logic [N_SEQ-1:0] seq_done;
  logic [CNT_W-1:0] period, count;
  logic             armed, expire, pulse_act;
  logic             flag, ie, wake_en;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign per_wr  = wr_en && (wr_addr == A_PERIOD);
  assign stat_wr = wr_en && (wr_addr == A_STAT);

  for (genvar g = 0; g < N_SEQ; g++) begin : g_seq
    wdog_seq_bit u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pulse_act),
      .wr      (ctrl_wr),
      .bit_val (wr_data[g]),
      .done    (seq_done[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      period <= CNT_W'(DEF_PERIOD);
    else if (per_wr) period <= wr_data[CNT_W-1:0];
  end

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pulse_act),
    .rst_mode (cfg_rst_mode),
    .arm_go   (seq_done[B_ARM]),
    .kick_go  (seq_done[B_KICK]),
    .stop_go  (seq_done[B_STOP]),
    .period   (period),
    .armed    (armed),
    .count    (count),
    .expire   (expire)
  );

  wdog_rst_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (expire && cfg_rst_mode),
    .active (pulse_act)
  );

  wdog_irq_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pulse_act),
    .set_flag (expire && !cfg_rst_mode),
    .ctrl_wr  (ctrl_wr),
    .ie_val   (wr_data[B_IE]),
    .wake_val (wr_data[B_WAKE]),
    .stat_wr  (stat_wr),
    .stat_bit (wr_data[0]),
    .glb_en   (glb_irq_en),
    .idle     (idle_i),
    .flag     (flag),
    .ie       (ie),
    .wake_en  (wake_en),
    .irq      (irq_o),
    .wake     (wake_o)
  );

  assign sys_rst_o = pulse_act;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[B_ARM]  = armed;
        rd_data[B_IE]   = ie;
        rd_data[B_WAKE] = wake_en;
      end
      A_PERIOD: rd_data = DATA_W'(period);
      A_STAT:   rd_data[0] = flag;
      default:  rd_data = DATA_W'(count);
    endcase
  end

  // R5: a reset pulse only starts in reset mode
  a_r5_pulse_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> cfg_rst_mode);
  // R10: the pulse leaves the watchdog disarmed
  a_r10_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> !armed);
  // R9: wake never without the interrupt request
  a_r9_wake_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (irq_o && idle_i));
endmodule

// File: tb/test_wdog_seq_top.sv
module test_wdog_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        cfg_rst_mode = 1'b0;
  logic        glb_irq_en = 1'b0;
  logic        idle_i = 1'b0;
  logic        sys_rst_o, irq_o, wake_o;

  int n_chk = 0;
  int n_fail = 0;
  logic ie_v = 1'b0;
  logic wk_v = 1'b0;

  always #5 clk = ~clk;

  wdog_seq_top i_wdog_seq_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg_rst_mode(cfg_rst_mode), .glb_irq_en(glb_irq_en), .idle_i(idle_i),
    .sys_rst_o(sys_rst_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  // period, cycles waited after the arming edge, expected flag
  localparam logic [24:0] VEC [0:5] = '{
    {16'd5,  8'd5,  1'b0},
    {16'd5,  8'd6,  1'b1},
    {16'd10, 8'd10, 1'b0},
    {16'd10, 8'd11, 1'b1},
    {16'd3,  8'd4,  1'b1},
    {16'd0,  8'd1,  1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic ctrl(input logic arm, input logic kick, input logic stop);
    wr(2'd0, {11'd0, wk_v, ie_v, stop, kick, arm});
  endtask

  task automatic do_arm;  ctrl(1, 0, 0); ctrl(0, 0, 0); endtask
  task automatic do_stop; ctrl(0, 0, 1); ctrl(0, 0, 0); endtask
  task automatic do_kick; ctrl(0, 1, 0); ctrl(0, 0, 0); endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(2'd3, v); check("R12 count after reset", v, 0);
    rd(2'd0, v); check("R12 ctrl after reset", v, 0);
    rd(2'd1, v); check("R12 period after reset", v, 1000);
    check("R10 no reset pulse after reset", sys_rst_o, 0);
    check("R6 no irq after reset", irq_o, 0);

    // R4 R11 table of expiry timings in interrupt mode
    ie_v = 1'b1; glb_irq_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      do_stop();
      wr(2'd2, 16'd0);
      wr(2'd1, VEC[i][24:9]);
      do_arm();
      tick(int'(VEC[i][8:1]));
      rd(2'd2, v); check("R4 flag at expiry boundary", v[0], VEC[i][0]);
      if (VEC[i][0]) begin
        rd(2'd3, v); check("R11 count reloaded after firing", v, VEC[i][24:9]);
        check("R6 irq with both enables", irq_o, 1);
      end
    end

    // R6 gating
    ie_v = 1'b0; ctrl(0, 0, 0);
    check("R6 irq blocked by local enable", irq_o, 0);
    ie_v = 1'b1; ctrl(0, 0, 0); glb_irq_en = 1'b0; #1;
    check("R6 irq blocked by global enable", irq_o, 0);
    glb_irq_en = 1'b1; #1;
    check("R6 irq restored", irq_o, 1);

    // R9 wake
    idle_i = 1'b1; #1;
    check("R9 no wake without wake enable", wake_o, 0);
    wk_v = 1'b1; ctrl(0, 0, 0);
    check("R9 wake when idle and enabled", wake_o, 1);
    idle_i = 1'b0; #1;
    check("R9 no wake when not idle", wake_o, 0);
    wk_v = 1'b0; ctrl(0, 0, 0);

    // R7 sticky flag
    do_stop();
    tick(20);
    rd(2'd2, v); check("R7 flag stays set", v[0], 1);
    wr(2'd2, 16'd1);
    rd(2'd2, v); check("R7 writing 1 keeps flag", v[0], 1);
    wr(2'd2, 16'd0);
    rd(2'd2, v); check("R7 writing 0 clears flag", v[0], 0);

    // R1 count step and R8 service reload
    wr(2'd1, 16'd10);
    do_arm();
    rd(2'd3, v); check("R1 count loaded on arm", v, 10);
    tick(6);
    rd(2'd3, v); check("R1 count after 6 clocks", v, 4);
    do_kick();
    rd(2'd3, v); check("R8 service reloads count", v, 10);
    tick(10);
    rd(2'd2, v); check("R8 no fire before new expiry", v[0], 0);
    tick(1);
    rd(2'd2, v); check("R8 fires after reloaded period", v[0], 1);
    wr(2'd2, 16'd0);

    // R2 single writes do not disable
    wr(2'd1, 16'd40);
    do_arm();
    ctrl(0, 0, 1);
    tick(3);
    rd(2'd0, v); check("R2 lone 1 keeps armed", v[0], 1);
    rd(2'd3, v); check("R2 count still running", v, 36);
    ctrl(0, 0, 0);
    rd(2'd0, v); check("R2 1-then-0 disables", v[0], 0);
    do_arm();
    ctrl(0, 0, 0);
    rd(2'd0, v); check("R2 lone 0 keeps armed", v[0], 1);

    // R3 disabled behaviour
    do_stop();
    rd(2'd3, v);
    tick(50);
    begin
      logic [15:0] v2;
      rd(2'd3, v2); check("R3 count holds while disabled", v2, v);
    end
    rd(2'd2, v); check("R3 no fire while disabled", v[0], 0);
    do_kick();
    rd(2'd0, v); check("R3 service does not re-arm", v[0], 0);

    // R5 R10 reset mode
    cfg_rst_mode = 1'b1;
    wr(2'd1, 16'd4);
    wk_v = 1'b1;
    do_arm();
    tick(4);
    check("R10 no pulse before expiry", sys_rst_o, 0);
    for (int k = 0; k < 4; k++) begin
      tick(1);
      check("R10 pulse high", sys_rst_o, 1);
    end
    tick(1);
    check("R10 pulse ends after 4 clocks", sys_rst_o, 0);
    rd(2'd0, v); check("R10 control state cleared", v, 0);
    rd(2'd1, v); check("R10 period kept", v, 4);
    rd(2'd2, v); check("R5 no flag in reset mode", v[0], 0);
    check("R5 no irq in reset mode", irq_o, 0);
    cfg_rst_mode = 1'b0;

    finish_run();
  end
endmodule